// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the bus-facing register file of a small serial port controller. An APB master reaches six word addresses through it. It stores the character format (word length, stop length and parity), a 32-bit baud divisor and a word of interrupt masks and engine halt controls. Through the same window it passes bytes to the transmit queue and takes bytes from the receive queue. The serial engines and the two queues sit outside the block. They talk to it over single-cycle push and pop strobes, full and empty levels, and four one-cycle event pulses: character received, character sent, parity fault and stop fault.

The block collects those events into sticky flags. Each flag follows its own clearing rule. It then drives an active-low interrupt line from the flags whose mask bits are zero. A one-cycle reset pulse can be sent to the engines and queues without disturbing the stored configuration.

Top module: `uart_regbank`

## Requirements
- R1: After synchronous reset the line-format word reads 0, the mask/control word reads 0x3F, the baud word reads 0, the status word reads 0 apart from its live level bits, `irq_n` is 1 and `eng_rst` is 0.
- R2: The line-format word at address 0 keeps bits [5:0] and drives them out. `word_len` is bits [1:0] (00 = 8 data bits, 01 = 7, 10 = 6, 11 = 5). `stop_len` is bits [3:2] (00 = one, 01 = one and a half, 10 = two). `parity_mode` is bits [5:4] (00 even, 01 odd, 10 none). Bits [31:6] read as 0.
- R3: The baud word at address 2 stores all 32 written bits, reads them back and drives `baud_count`.
- R4: The control word at address 1 keeps mask bits [5:0], `rx_halt` in bit 7 and `tx_halt` in bit 8, and bits [31:9] read 0. A mask bit of 1 blocks the matching interrupt source.
- R5: Writing 1 to bit 6 of address 1 drives `eng_rst` high for exactly the one cycle after the access. Bit 6 then reads 0, and the format, baud and mask values keep their contents.
- R6: Status bits 0 to 3 (received, sent, parity fault, stop fault) are set by their event inputs and stay set. A status write clears each bit where it writes 0 and leaves each bit where it writes 1. An event in the same cycle as its clearing write keeps the bit set.
- R7: Status bit 4 sets when the receive queue becomes full and clears on a read of address 4.
- R8: Status bit 7 sets when the transmit queue becomes empty and clears on a write of address 5. It is not set by the queue being empty at reset.
- R9: Status bit 5 shows the live receive-empty level and bit 6 the live transmit-full level.
- R10: `irq_n` is 0 exactly while some status flag is set whose mask bit is 0. The mask bits map to flags as follows: mask 0 to flag 0, mask 1 to 1, mask 2 to 2, mask 3 to 3, mask 4 to flag 4 and mask 5 to flag 7.
- R11: A read of address 4 returns `rx_rdata` and pulses `rx_pop` once, only when the queue is not empty. A write of address 5 pulses `tx_push` with `pwdata[7:0]` on `tx_wdata`, only when the queue is not full.
- R12: Reads of addresses 5 to 31 return 0, and writes to addresses 4 and 6 to 31 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 5 | APB word address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| irq_n | output | 1 | Interrupt, active low |
| word_len | output | 2 | Data bit count code |
| stop_len | output | 2 | Stop length code |
| parity_mode | output | 2 | Parity code |
| baud_count | output | 32 | Baud divisor |
| rx_halt | output | 1 | Receiver stop request |
| tx_halt | output | 1 | Transmitter stop request |
| eng_rst | output | 1 | One-cycle reset to engines and queues |
| tx_push | output | 1 | Transmit queue push strobe |
| tx_wdata | output | 8 | Byte to push |
| tx_full | input | 1 | Transmit queue full |
| tx_empty | input | 1 | Transmit queue empty |
| rx_pop | output | 1 | Receive queue pop strobe |
| rx_rdata | input | 8 | Head byte of receive queue |
| rx_full | input | 1 | Receive queue full |
| rx_empty | input | 1 | Receive queue empty |
| ev_rx_done | input | 1 | Character received pulse |
| ev_tx_done | input | 1 | Character sent pulse |
| ev_par_err | input | 1 | Parity fault pulse |
| ev_stop_err | input | 1 | Stop fault pulse |

## Verification
The hardest case to reach from the ports is an event pulse that falls in the same edge as a status write clearing that flag. The bench handles it by opening an APB write cycle by hand and raising the stop-fault input together with `penable`, so both land on one edge. The flag-4 and flag-7 cases are reached by filling a bench model of the receive queue to its limit and by draining a bench model of the transmit queue back to empty. Each of these edges is then followed by a status read.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

    localparam int N_REG      = 6;
    localparam int N_STICKY   = 4;
    localparam int N_IRQ      = 6;

    localparam int REG_LINE   = 0;
    localparam int REG_CTL    = 1;
    localparam int REG_BAUD   = 2;
    localparam int REG_STAT   = 3;
    localparam int REG_RXD    = 4;
    localparam int REG_TXD    = 5;

    typedef enum logic [1:0] {WL_8 = 2'd0, WL_7 = 2'd1, WL_6 = 2'd2, WL_5 = 2'd3} wlen_e;
    typedef enum logic [1:0] {SB_1 = 2'd0, SB_1P5 = 2'd1, SB_2 = 2'd2, SB_RSV = 2'd3} stop_e;
    typedef enum logic [1:0] {PAR_EVEN = 2'd0, PAR_ODD = 2'd1, PAR_NONE = 2'd2, PAR_RSV = 2'd3} parity_e;

    typedef struct packed {
        parity_e par;
        stop_e   stop;
        wlen_e   wlen;
    } line_cfg_t;

    typedef struct packed {
        logic             tx_halt;
        logic             rx_halt;
        logic             soft_rst;
        logic [N_IRQ-1:0] irq_mask;
    } ctl_t;

    typedef struct packed {
        logic tx_empty_f;
        logic tx_full_lv;
        logic rx_empty_lv;
        logic rx_full_f;
        logic stop_err;
        logic par_err;
        logic tx_done;
        logic rx_done;
    } stat_t;

    typedef struct packed {
        logic wr_line;
        logic wr_ctl;
        logic wr_baud;
        logic wr_stat;
        logic wr_txd;
        logic rd_rxd;
        logic rd_any;
    } access_t;

    localparam line_cfg_t LINE_RST = '{par: PAR_EVEN, stop: SB_1, wlen: WL_8};
    localparam ctl_t      CTL_RST  = '{tx_halt: 1'b0, rx_halt: 1'b0, soft_rst: 1'b0,
                                       irq_mask: {N_IRQ{1'b1}}};

    function automatic logic [N_IRQ-1:0] irq_sources(input stat_t s);
        return {s.tx_empty_f, s.rx_full_f, s.stop_err, s.par_err, s.tx_done, s.rx_done};
    endfunction

endpackage

// File: rtl/uart_apb_decode.sv
module uart_apb_decode
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output access_t           acc
);
    logic             live;
    logic [N_REG-1:0] hit;

    assign live = psel & penable;

    for (genvar i = 0; i < N_REG; i++) begin : g_hit
        assign hit[i] = (paddr == ADDR_W'(i));
    end

    always_comb begin
        acc         = '0;
        acc.wr_line = live & pwrite & hit[REG_LINE];
        acc.wr_ctl  = live & pwrite & hit[REG_CTL];
        acc.wr_baud = live & pwrite & hit[REG_BAUD];
        acc.wr_stat = live & pwrite & hit[REG_STAT];
        acc.wr_txd  = live & pwrite & hit[REG_TXD];
        acc.rd_rxd  = live & ~pwrite & hit[REG_RXD];
        acc.rd_any  = psel & ~pwrite;
    end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
    import uart_reg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_line,
    input  logic              wr_ctl,
    input  logic              wr_baud,
    input  logic [DATA_W-1:0] wdata,
    output line_cfg_t         line_q,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] baud_q
);
    localparam int LINE_W = $bits(line_cfg_t);
    localparam int CTL_W  = $bits(ctl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LINE_RST;
            ctl_q  <= CTL_RST;
            baud_q <= '0;
        end else begin
            if (wr_line) line_q <= line_cfg_t'(wdata[LINE_W-1:0]);
            if (wr_baud) baud_q <= wdata;
            if (wr_ctl) ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
            else        ctl_q.soft_rst <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
    import uart_reg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [N_STICKY-1:0] ev,
    input  logic                wr_stat,
    input  logic [N_STICKY-1:0] wdata,
    input  logic                rd_rxd,
    input  logic                wr_txd,
    input  logic                rx_full,
    input  logic                rx_empty,
    input  logic                tx_full,
    input  logic                tx_empty,
    output stat_t               stat_o
);
    logic [N_STICKY-1:0] sticky_q;
    logic                rxf_flag_q, txe_flag_q;
    logic                rx_full_d, tx_empty_d;

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)                     sticky_q[i] <= 1'b0;
            else if (ev[i])              sticky_q[i] <= 1'b1;
            else if (wr_stat && !wdata[i]) sticky_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full_d  <= 1'b0;
            tx_empty_d <= 1'b1;
            rxf_flag_q <= 1'b0;
            txe_flag_q <= 1'b0;
        end else begin
            rx_full_d  <= rx_full;
            tx_empty_d <= tx_empty;
            if (rx_full && !rx_full_d) rxf_flag_q <= 1'b1;
            else if (rd_rxd)           rxf_flag_q <= 1'b0;
            if (tx_empty && !tx_empty_d) txe_flag_q <= 1'b1;
            else if (wr_txd)             txe_flag_q <= 1'b0;
        end
    end

    always_comb begin
        stat_o             = '0;
        stat_o.rx_done     = sticky_q[0];
        stat_o.tx_done     = sticky_q[1];
        stat_o.par_err     = sticky_q[2];
        stat_o.stop_err    = sticky_q[3];
        stat_o.rx_full_f   = rxf_flag_q;
        stat_o.rx_empty_lv = rx_empty;
        stat_o.tx_full_lv  = tx_full;
        stat_o.tx_empty_f  = txe_flag_q;
    end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_reg_pkg::*;
(
    input  stat_t            stat,
    input  logic [N_IRQ-1:0] mask,
    output logic             irq_n
);
    logic [N_IRQ-1:0] pending;

    assign pending = irq_sources(stat) & ~mask;
    assign irq_n   = ~(|pending);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq_n,
    output logic [1:0]        word_len,
    output logic [1:0]        stop_len,
    output logic [1:0]        parity_mode,
    output logic [DATA_W-1:0] baud_count,
    output logic              rx_halt,
    output logic              tx_halt,
    output logic              eng_rst,
    output logic              tx_push,
    output logic [CHAR_W-1:0] tx_wdata,
    input  logic              tx_full,
    input  logic              tx_empty,
    output logic              rx_pop,
    input  logic [CHAR_W-1:0] rx_rdata,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              ev_rx_done,
    input  logic              ev_tx_done,
    input  logic              ev_par_err,
    input  logic              ev_stop_err
);
    access_t             acc;
    line_cfg_t           line_q;
    ctl_t                ctl_q;
    logic [DATA_W-1:0]   baud_q;
    stat_t               stat_q;

    uart_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .acc(acc)
    );

    uart_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst(rst),
        .wr_line(acc.wr_line), .wr_ctl(acc.wr_ctl), .wr_baud(acc.wr_baud),
        .wdata(pwdata),
        .line_q(line_q), .ctl_q(ctl_q), .baud_q(baud_q)
    );

    uart_status_flags u_stat (
        .clk(clk), .rst(rst),
        .ev({ev_stop_err, ev_par_err, ev_tx_done, ev_rx_done}),
        .wr_stat(acc.wr_stat), .wdata(pwdata[N_STICKY-1:0]),
        .rd_rxd(acc.rd_rxd), .wr_txd(acc.wr_txd),
        .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_full(tx_full), .tx_empty(tx_empty),
        .stat_o(stat_q)
    );

    uart_irq_gen u_irq (
        .stat(stat_q), .mask(ctl_q.irq_mask), .irq_n(irq_n)
    );

    assign word_len    = line_q.wlen;
    assign stop_len    = line_q.stop;
    assign parity_mode = line_q.par;
    assign baud_count  = baud_q;
    assign rx_halt     = ctl_q.rx_halt;
    assign tx_halt     = ctl_q.tx_halt;
    assign eng_rst     = ctl_q.soft_rst;

    assign rx_pop   = acc.rd_rxd & ~rx_empty;
    assign tx_push  = acc.wr_txd & ~tx_full;
    assign tx_wdata = pwdata[CHAR_W-1:0];

    always_comb begin
        prdata = '0;
        if (acc.rd_any) begin
            case (paddr)
                ADDR_W'(REG_LINE): prdata = DATA_W'(line_q);
                ADDR_W'(REG_CTL):  prdata = DATA_W'(ctl_q);
                ADDR_W'(REG_BAUD): prdata = baud_q;
                ADDR_W'(REG_STAT): prdata = DATA_W'(stat_q);
                ADDR_W'(REG_RXD):  prdata = DATA_W'(rx_rdata);
                default:           prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              irq_n,
    input logic              eng_rst,
    input logic              tx_push,
    input logic [CHAR_W-1:0] tx_wdata,
    input logic              tx_full,
    input logic              rx_pop,
    input logic              rx_empty,
    input logic              ev_par_err,
    input logic [7:0]        stat_bits,
    input logic [8:0]        ctl_bits
);
    logic stat_clr_par;
    assign stat_clr_par = psel && penable && pwrite && (paddr == ADDR_W'(3)) && !pwdata[2];

    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (rst)
        eng_rst |=> !eng_rst);

    assert_soft_hit_R5: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && paddr == ADDR_W'(1) && pwdata[6]) |=> eng_rst);

    assert_pop_guard_R11: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (!rx_empty && psel && penable && !pwrite && paddr == ADDR_W'(4)));

    assert_push_guard_R11: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (!tx_full && psel && penable && pwrite && paddr == ADDR_W'(5)
                     && tx_wdata == pwdata[CHAR_W-1:0]));

    assert_sticky_set_R6: assert property (@(posedge clk) disable iff (rst)
        ev_par_err |=> stat_bits[2]);

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_bits[2] && !stat_clr_par) |=> stat_bits[2]);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (ctl_bits[5:0] != 6'h3f));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr > ADDR_W'(5)) |-> (prdata == '0));
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_n(irq_n),
    .eng_rst(eng_rst), .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_empty(rx_empty), .ev_par_err(ev_par_err),
    .stat_bits(stat_q), .ctl_bits(ctl_q)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_n, rx_halt, tx_halt, eng_rst, tx_push, rx_pop;
    logic [1:0]  word_len, stop_len, parity_mode;
    logic [31:0] baud_count;
    logic [7:0]  tx_wdata, rx_rdata;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic        ev_rx_done = 0, ev_tx_done = 0, ev_par_err = 0, ev_stop_err = 0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // queue models
    logic [7:0] rmem [4];
    logic [7:0] tmem [4];
    int rhead = 0, rcnt = 0, thead = 0, tcnt = 0;
    logic       rx_load = 0, tx_drain = 0;
    logic [7:0] rx_load_d = '0;
    logic [7:0] last_tx = '0;

    assign rx_empty = (rcnt == 0);
    assign rx_full  = (rcnt == 4);
    assign rx_rdata = rmem[rhead];
    assign tx_empty = (tcnt == 0);
    assign tx_full  = (tcnt == 4);

    initial for (int i = 0; i < 4; i++) begin rmem[i] = '0; tmem[i] = '0; end

    always @(posedge clk) begin
        if (eng_rst) begin
            rcnt <= 0; rhead <= 0; tcnt <= 0; thead <= 0;
        end else begin
            if (rx_load && rcnt < 4) rmem[(rhead + rcnt) % 4] <= rx_load_d;
            if (rx_pop) rhead <= (rhead + 1) % 4;
            rcnt <= rcnt + ((rx_load && rcnt < 4) ? 1 : 0) - (rx_pop ? 1 : 0);
            if (tx_push) begin
                tmem[(thead + tcnt) % 4] <= tx_wdata;
                last_tx <= tx_wdata;
            end
            if (tx_drain && tcnt > 0) thead <= (thead + 1) % 4;
            tcnt <= tcnt + (tx_push ? 1 : 0) - ((tx_drain && tcnt > 0) ? 1 : 0);
        end
    end

    uart_regbank u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_n(irq_n),
        .word_len(word_len), .stop_len(stop_len), .parity_mode(parity_mode),
        .baud_count(baud_count), .rx_halt(rx_halt), .tx_halt(tx_halt),
        .eng_rst(eng_rst), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_empty(rx_empty),
        .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done),
        .ev_par_err(ev_par_err), .ev_stop_err(ev_stop_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        case (idx)
            0: ev_rx_done = 1;
            1: ev_tx_done = 1;
            2: ev_par_err = 1;
            default: ev_stop_err = 1;
        endcase
        @(negedge clk);
        ev_rx_done = 0; ev_tx_done = 0; ev_par_err = 0; ev_stop_err = 0;
        #1;
    endtask

    task automatic load_rx(input logic [7:0] b);
        @(negedge clk);
        rx_load = 1; rx_load_d = b;
        @(negedge clk);
        rx_load = 0;
    endtask

    task automatic drain_tx();
        @(negedge clk);
        tx_drain = 1;
        repeat (5) @(negedge clk);
        tx_drain = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
        chk("R1 eng_rst", {31'd0, eng_rst}, 32'd0);
        apb_read(5'd0, d); chk("R1 line", d, 32'h0);
        apb_read(5'd1, d); chk("R1 ctl", d, 32'h3F);
        apb_read(5'd2, d); chk("R1 baud", d, 32'h0);
        apb_read(5'd3, d); chk("R1 R9 status", d, 32'h20);
    endtask

    task automatic t_line();
        logic [31:0] d;
        apb_write(5'd0, 32'h0000_002B);
        apb_read(5'd0, d); chk("R2 readback", d, 32'h2B);
        chk("R2 fields", {26'd0, parity_mode, stop_len, word_len}, 32'h2B);
        apb_write(5'd0, 32'hFFFF_FFD6);
        apb_read(5'd0, d); chk("R2 reserved zero", d, 32'h16);
        chk("R2 word_len 6 bits", {30'd0, word_len}, 32'h2);
    endtask

    task automatic t_baud();
        logic [31:0] d;
        apb_write(5'd2, 32'h0000_01A9);
        apb_read(5'd2, d); chk("R3 baud 0x1A9", d, 32'h1A9);
        apb_write(5'd2, 32'hDEAD_BEEF);
        apb_read(5'd2, d); chk("R3 baud full", d, 32'hDEAD_BEEF);
        chk("R3 baud_count", baud_count, 32'hDEAD_BEEF);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        apb_write(5'd1, 32'hFFFF_FE95);
        apb_read(5'd1, d); chk("R4 ctl", d, 32'h095);
        chk("R4 halts", {30'd0, tx_halt, rx_halt}, 32'h1);
        apb_write(5'd1, 32'h0000_0100);
        #1 chk("R4 tx_halt", {30'd0, tx_halt, rx_halt}, 32'h2);
        apb_write(5'd1, 32'h3F);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(2);
        apb_read(5'd3, d); chk("R6 par set", d & 32'h0F, 32'h04);
        chk("R10 masked", {31'd0, irq_n}, 32'd1);
        apb_write(5'd1, 32'h3B);
        #1 chk("R10 unmasked", {31'd0, irq_n}, 32'd0);
        apb_write(5'd3, 32'hFF);
        apb_read(5'd3, d); chk("R6 write one keeps", d & 32'h0F, 32'h04);
        pulse(0);
        apb_write(5'd3, 32'hFB);
        apb_read(5'd3, d); chk("R6 selective clear", d & 32'h0F, 32'h01);
        chk("R10 other masked", {31'd0, irq_n}, 32'd1);
        apb_write(5'd1, 32'h3E);
        #1 chk("R10 bit0", {31'd0, irq_n}, 32'd0);
        pulse(1); pulse(3);
        apb_write(5'd3, 32'h0);
        apb_read(5'd3, d); chk("R6 clear all", d & 32'h0F, 32'h0);
        chk("R10 none pending", {31'd0, irq_n}, 32'd1);
        // event on same edge as clearing write
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = 5'd3; pwdata = 32'h0;
        @(negedge clk);
        penable = 1; ev_stop_err = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0; ev_stop_err = 0;
        apb_read(5'd3, d); chk("R6 set wins", d & 32'h0F, 32'h08);
        apb_write(5'd3, 32'h0);
        apb_write(5'd1, 32'h3F);
    endtask

    task automatic t_rxfull();
        logic [31:0] d;
        apb_write(5'd1, 32'h2F);
        load_rx(8'h11); load_rx(8'h22); load_rx(8'h33); load_rx(8'h44);
        @(negedge clk); #1;
        chk("R10 full irq", {31'd0, irq_n}, 32'd0);
        apb_read(5'd3, d); chk("R7 R9 full flag", d & 32'h30, 32'h10);
        apb_read(5'd4, d); chk("R11 first byte", d, 32'h11);
        apb_read(5'd3, d); chk("R7 cleared on read", d & 32'h30, 32'h00);
        chk("R10 irq released", {31'd0, irq_n}, 32'd1);
        apb_read(5'd4, d); chk("R11 byte 2", d, 32'h22);
        apb_read(5'd4, d); chk("R11 byte 3", d, 32'h33);
        apb_read(5'd4, d); chk("R11 byte 4", d, 32'h44);
        apb_read(5'd4, d);
        chk("R11 no pop when empty", rcnt, 0);
        apb_read(5'd3, d); chk("R9 empty level", d & 32'h20, 32'h20);
        apb_write(5'd1, 32'h3F);
    endtask

    task automatic t_txempty();
        logic [31:0] d;
        apb_write(5'd5, 32'hFFFF_FF5A);
        chk("R11 pushed byte", {24'd0, last_tx}, 32'h5A);
        chk("R11 push count", tcnt, 1);
        apb_read(5'd3, d); chk("R8 no flag yet", d & 32'h80, 32'h0);
        drain_tx();
        apb_read(5'd3, d); chk("R8 set on empty", d & 32'h80, 32'h80);
        apb_write(5'd1, 32'h1F);
        #1 chk("R10 tx empty irq", {31'd0, irq_n}, 32'd0);
        apb_write(5'd5, 32'h01);
        apb_read(5'd3, d); chk("R8 cleared on write", d & 32'h80, 32'h0);
        apb_write(5'd5, 32'h02); apb_write(5'd5, 32'h03); apb_write(5'd5, 32'h04);
        apb_read(5'd3, d); chk("R9 tx full level", d & 32'h40, 32'h40);
        apb_write(5'd5, 32'h77);
        chk("R11 no push when full", tcnt, 4);
        chk("R11 last byte kept", {24'd0, last_tx}, 32'h04);
        drain_tx();
        apb_write(5'd3, 32'h0);
        apb_read(5'd3, d); chk("R8 write zero ignored", d & 32'h80, 32'h80);
        apb_write(5'd1, 32'h3F);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        apb_read(5'd5, d);  chk("R12 read 5", d, 32'h0);
        apb_read(5'd6, d);  chk("R12 read 6", d, 32'h0);
        apb_read(5'd31, d); chk("R12 read 31", d, 32'h0);
        apb_write(5'd7, 32'hFFFF_FFFF);
        apb_write(5'd4, 32'hFFFF_FFFF);
        apb_read(5'd0, d); chk("R12 line intact", d, 32'h16);
        apb_read(5'd1, d); chk("R12 ctl intact", d, 32'h3F);
        apb_read(5'd2, d); chk("R12 baud intact", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        load_rx(8'hA5); load_rx(8'h5A);
        apb_write(5'd1, 32'h7F);
        #1 chk("R5 pulse high", {31'd0, eng_rst}, 32'd1);
        @(negedge clk); #1 chk("R5 pulse low", {31'd0, eng_rst}, 32'd0);
        apb_read(5'd1, d); chk("R5 bit self clears", d, 32'h3F);
        apb_read(5'd0, d); chk("R5 line kept", d, 32'h16);
        apb_read(5'd2, d); chk("R5 baud kept", d, 32'hDEAD_BEEF);
        apb_read(5'd3, d); chk("R5 queue reset", d & 32'h20, 32'h20);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_line();
        t_baud();
        t_mask();
        t_sticky();
        t_rxfull();
        t_txempty();
        t_unmapped();
        t_soft();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule